// File: doc/BRIEF.md
# PHY Management Register File

This block stands in for the management register set of an Ethernet PHY. A host issues single-cycle read or write requests carrying a 5-bit PHY address, a 5-bit register number and 16-bit write data. Read results come back one clock later on a registered data port.

The block answers only at its own PHY address and keeps ordinary writable registers that start from fixed reset values. The status, link-partner ability and speed/duplex registers are not stored. They are computed from the local advertisement register, so a driver always finds autonegotiation finished, the link up, and the partner agreeing with whatever it advertised. The control register's reset and restart-negotiation bits clear themselves on every write. The serial wire protocol and the real negotiation exchange are not modelled.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After reset, register 0 reads 0x3100, register 2 reads 0x0300, register 3 reads 0xE400 and register 4 reads 0x01E1. Any other stored register that has never been written reads 0x0000.
- R2: Register 1 always reads 0x782E, which has bits 14, 13, 12, 11, 5, 3, 2 and 1 set. Writes to it do not change what is read.
- R3: Register 5 reads 0x4000 ORed with bits 8:5 of register 4. All other bits read zero.
- R4: Register 17 reads bit 10 set when register 4 bit 7 or bit 8 is set (100 Mb/s). It reads bit 11 set when register 4 bit 8 or bit 6 is set (full duplex). All other bits read zero.
- R5: Register 26 always reads 0x8000, which reports 1000 Mb/s.
- R6: A write to register 0 stores the data with bits 15 and 9 forced to zero.
- R7: Every other register reads back the last value written to it.
- R8: A read to a PHY address other than the parameter PHY_ADDR (default 7) returns 0xFFFF. A write to such an address changes no register.
- R9: A read strobe (req_valid high, req_write low) gives rd_valid high, with its data on rd_data, in the following cycle. rd_data holds its value until the next read. After reset, rd_valid and rd_data are zero.
- R10: rd_valid stays low in every cycle that does not follow a read strobe, including the cycles after writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 5 | Register number |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read strobe |
| rd_data | output | 16 | Read data, held until the next read |

## Verification
The assertions assume that req_valid and req_write are never unknown once reset is released. They also assume that a request lasts exactly one cycle, so back-to-back strobes are treated as separate accesses. The bench keeps to this by driving every request field on the falling edge and by keeping req_valid low in idle cycles. Its pseudo-random phase issues at most one access per cycle and draws PHY addresses that include both the block's own address and foreign ones.

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile #(
  parameter int         AW       = 5,
  parameter logic [4:0] PHY_ADDR = 5'd7,
  parameter int         SPD_REG  = 17,
  parameter int         VEND_REG = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_phy,
  input  logic [AW-1:0] req_reg,
  input  logic [15:0]   req_wdata,
  output logic          rd_valid,
  output logic [15:0]   rd_data
);
  localparam int NREG = 1 << AW;
  localparam logic [15:0] STAT_VAL  = 16'h782E;
  localparam logic [15:0] SELF_CLR  = 16'h8200;
  localparam logic [15:0] GIG_VAL   = 16'h8000;
  localparam logic [15:0] ABSENT    = 16'hFFFF;

  logic [15:0] regs [NREG];
  logic [15:0] view;
  logic [15:0] adv;

  wire hit = (req_phy == PHY_ADDR[AW-1:0]);
  wire wr  = req_valid & req_write & hit;
  wire rd  = req_valid & ~req_write;

  assign adv = regs[4];

  function automatic logic [15:0] rst_val(input int idx);
    case (idx)
      0:       rst_val = 16'h3100;
      2:       rst_val = 16'h0300;
      3:       rst_val = 16'hE400;
      4:       rst_val = 16'h01E1;
      default: rst_val = 16'h0000;
    endcase
  endfunction

  always_comb begin
    if (req_reg == AW'(1))
      view = STAT_VAL;
    else if (req_reg == AW'(5))
      view = 16'h4000 | (adv & 16'h01E0);
    else if (req_reg == AW'(SPD_REG))
      view = {4'b0, adv[8] | adv[6], adv[8] | adv[7], 10'b0};
    else if (req_reg == AW'(VEND_REG))
      view = GIG_VAL;
    else
      view = regs[req_reg];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= rst_val(i);
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      if (wr)
        regs[req_reg] <= (req_reg == '0) ? (req_wdata & ~SELF_CLR) : req_wdata;
      if (rd)
        rd_data <= hit ? view : ABSENT;
    end
  end
endmodule

// File: rtl/phy_mgmt_regfile_chk.sv
module phy_mgmt_regfile_chk #(
  parameter int         AW       = 5,
  parameter logic [4:0] PHY_ADDR = 5'd7,
  parameter int         VEND_REG = 26
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic [AW-1:0] req_phy,
  input logic [AW-1:0] req_reg,
  input logic          rd_valid,
  input logic [15:0]   rd_data
);
  wire rd_s = req_valid & ~req_write;
  wire mine = (req_phy == PHY_ADDR[AW-1:0]);

  p_rd_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_s |=> rd_valid);
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_s |=> $stable(rd_data));
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_s |=> !rd_valid);
  p_foreign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_s && !mine |=> rd_data == 16'hFFFF);
  p_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_s && mine && req_reg == AW'(1) |=> rd_data == 16'h782E);
  p_partner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_s && mine && req_reg == AW'(5) |=>
      rd_data[14] && !rd_data[15] && rd_data[13:9] == 5'd0 && rd_data[4:0] == 5'd0);
  p_vendor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_s && mine && req_reg == AW'(VEND_REG) |=> rd_data == 16'h8000);
endmodule

bind phy_mgmt_regfile phy_mgmt_regfile_chk #(
  .AW(AW), .PHY_ADDR(PHY_ADDR), .VEND_REG(VEND_REG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_phy(req_phy), .req_reg(req_reg), .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/phy_mgmt_regfile_test.sv
module phy_mgmt_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        rd_valid;
  logic [15:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int m [32];
  bit          exp_v;
  logic [15:0] exp_d;

  always #10 clk = ~clk;

  phy_mgmt_regfile uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [15:0] model_read(input int r);
    logic [15:0] a;
    a = 16'(m[4]);
    if (r == 1) return 16'h782E;
    if (r == 5) return 16'h4000 | (a & 16'h01E0);
    if (r == 17) begin
      model_read = 16'h0000;
      if (a[7] || a[8]) model_read[10] = 1'b1;
      if (a[8] || a[6]) model_read[11] = 1'b1;
      return model_read;
    end
    if (r == 26) return 16'h8000;
    return 16'(m[r]);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m[i] = 0;
    m[0] = 'h3100; m[2] = 'h0300; m[3] = 'hE400; m[4] = 'h01E1;
    exp_v = 0; exp_d = 16'h0000;
  endtask

  task automatic check(input string tag);
    checks++;
    if (rd_valid !== exp_v || rd_data !== exp_d) begin
      fails++;
      $display("FAIL %s: actual valid=%0b data=%04h expected valid=%0b data=%04h",
               tag, rd_valid, rd_data, exp_v, exp_d);
    end
  endtask

  // one clock: drive at falling edge, compare at next falling edge
  task automatic cycle(input bit v, input bit w, input int phy, input int r,
                       input int d, input string tag);
    req_valid = v; req_write = w; req_phy = 5'(phy); req_reg = 5'(r);
    req_wdata = 16'(d);
    exp_v = v && !w;
    if (v && !w) exp_d = (phy == 7) ? model_read(r) : 16'hFFFF;
    if (v && w && phy == 7) m[r] = (r == 0) ? (d & 'h7DFF) : (d & 'hFFFF);
    @(negedge clk);
    check(tag);
  endtask

  task automatic rd(input int r, input string tag);
    cycle(1, 0, 7, r, 0, tag);
  endtask

  task automatic wr(input int r, input int d, input string tag);
    cycle(1, 1, 7, r, d, tag);
  endtask

  task automatic idle(input string tag);
    cycle(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R9 reset state");
    idle("R10 idle after reset");

    rd(0, "R1 reg0 reset"); rd(2, "R1 reg2 reset");
    rd(3, "R1 reg3 reset"); rd(4, "R1 reg4 reset");
    rd(9, "R1 unwritten reads zero");

    rd(1, "R2 status"); wr(1, 'h0000, "R10 write no valid");
    rd(1, "R2 status after write");

    rd(5, "R3 partner default"); rd(17, "R4 speed default");
    wr(4, 'h0041, "R10"); rd(5, "R3 10full"); rd(17, "R4 10full");
    wr(4, 'h0081, "R10"); rd(5, "R3 100half"); rd(17, "R4 100half");
    wr(4, 'h0101, "R10"); rd(5, "R3 100full"); rd(17, "R4 100full");
    wr(4, 'hFE1F, "R10"); rd(5, "R3 masked"); rd(17, "R4 none");

    rd(26, "R5 vendor"); wr(26, 'h1234, "R10"); rd(26, "R5 vendor after write");

    wr(0, 'hFFFF, "R10"); rd(0, "R6 selfclear all ones");
    wr(0, 'h1234, "R10"); rd(0, "R6 selfclear pattern");

    wr(9, 'hABCD, "R10"); wr(31, 'h5A5A, "R10"); wr(2, 'h0000, "R10");
    rd(9, "R7 reg9"); rd(31, "R7 reg31"); rd(2, "R7 reg2 cleared");

    cycle(1, 0, 3, 0, 0, "R8 foreign read");
    cycle(1, 1, 8, 9, 'h1111, "R8 foreign write");
    rd(9, "R8 foreign write ignored");

    idle("R9 hold"); idle("R9 hold again");
    rd(2, "R9 back to back a"); rd(3, "R9 back to back b");

    for (int k = 0; k < 400; k++) begin
      int op, phy, r;
      op  = $urandom_range(0, 2);
      phy = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 31) : 7;
      r   = $urandom_range(0, 31);
      if (op == 0) idle("R10 random idle");
      else if (op == 1) cycle(1, 1, phy, r, $urandom_range(0, 65535), "R7 random write");
      else cycle(1, 0, phy, r, 0, "R7 random read");
    end

    rst_n = 1'b0; req_valid = 1'b0;
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    check("R9 second reset");
    rd(4, "R1 reg4 after second reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule